// File: doc/BRIEF.md
# Flash Program/Erase Status Sequencer

This block holds the status and sequencing logic that a flash controller shows to its host. A command port takes program, erase and clear-status requests. Program and erase run a loop: the block drives a pulse for a fixed number of cycles, then takes one verify sample from a stub input. The loop repeats until the sample passes or a per-operation pulse budget runs out. The analog pulse and the array itself sit outside the block. `verify_ok` stands in for the array's verify result.

The host reads an 8-bit status word. One bit shows that the engine is idle. Three sticky error bits record erase failure, program failure and an attempt made while writes were not enabled. An error bit stays set until a clear-status command or reset. While any error bit is set, each new program or erase request is rejected: the block reports it as failed without pulsing the array.

Top module: `flash_pe_status`

## Requirements
- R1: `status` is laid out as {idle, 0, erase_fail, prog_fail, wp_fail, 0, 0, 0}: bit 7 is 1 when the engine is idle, bit 5 is erase failure, bit 4 is program failure, bit 3 is write-protect violation, and bits 6 and 2..0 always read 0. After reset `status` is 8'h80.
- R2: A command is taken on a rising edge where `cmd_valid` is 1. `cmd_op` 2'b01 is program, 2'b10 is erase, 2'b11 is clear status, and 2'b00 does nothing.
- R3: An accepted program or erase makes bit 7 read 0 from the next cycle on. Each pulse holds `pulse_on` high for PULSE_CYCLES cycles, followed by one cycle with `pulse_on` low in which `verify_ok` is sampled. If the sample of pulse n passes, bit 7 reads 1 exactly n*(PULSE_CYCLES+1) cycles after the command edge.
- R4: Erase sets bit 5 only after ERASE_MAX pulses (default 8) have all failed verify. The bit is set in the same cycle that bit 7 returns to 1.
- R5: Program sets bit 4 only after PROG_MAX pulses (default 4) have all failed verify. The bit is set in the same cycle that bit 7 returns to 1.
- R6: A program or erase given with `prog_en` low sets bit 3 in the next cycle. No pulse is issued and bit 7 stays 1.
- R7: Bits 5, 4 and 3 are sticky. They fall only after a clear-status command accepted while idle, or after reset.
- R8: A program or erase given with `prog_en` high while any error bit is set issues no pulse. Bit 7 reads 0 for exactly one cycle. Bit 4 is also set for a program, and bit 5 for an erase.
- R9: Commands that arrive while bit 7 is 0 are ignored, including clear status.
- R10: A clear-status command accepted while idle makes bits 5, 4 and 3 read 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (01 program, 10 erase, 11 clear) |
| prog_en | input | 1 | Write enable; low blocks program and erase |
| verify_ok | input | 1 | Verify result stub, sampled in the verify cycle |
| pulse_on | output | 1 | High while a pulse is being applied |
| status | output | 8 | Status word |

## Verification
Every result comes from one register stage. A clear, a write-protect hit or a rejected command shows in `status` one cycle after the command edge. A rejected command keeps bit 7 low for exactly that one cycle. An operation that passes on pulse n returns to idle n*(PULSE_CYCLES+1) cycles after the command edge. A failed operation returns to idle after the full budget, with its flag set. The bench drives inputs and samples `status` and `pulse_on` on falling edges. It counts negedges from the command edge, sets `verify_ok` just before the verify edge of the chosen pulse, and checks the busy bit at every verify point and the final word one cycle after the last one. All pass points are swept, plus the no-pass case, for both operations.

// File: rtl/flash_pe_status.sv
module flash_pe_status #(
  parameter int PULSE_CYCLES = 3,
  parameter int ERASE_MAX    = 8,
  parameter int PROG_MAX     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       prog_en,
  input  logic       verify_ok,
  output logic       pulse_on,
  output logic [7:0] status
);
  localparam int TOP_MAX = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam int NW = $clog2(TOP_MAX + 1);
  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;
  localparam logic [1:0] OP_CLEAR = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_VERIFY, S_BLOCK} state_t;

  state_t        state;
  logic          is_erase;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] pnum;
  logic          erase_fail, prog_fail, wp_fail;

  wire idle    = (state == S_IDLE);
  wire any_err = erase_fail | prog_fail | wp_fail;
  wire is_pe   = (cmd_op == OP_PROG) | (cmd_op == OP_ERASE);
  wire [NW-1:0] budget = is_erase ? NW'(ERASE_MAX) : NW'(PROG_MAX);

  assign pulse_on = (state == S_PULSE);
  assign status   = {idle, 1'b0, erase_fail, prog_fail, wp_fail, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      is_erase   <= 1'b0;
      tcnt       <= '0;
      pnum       <= '0;
      erase_fail <= 1'b0;
      prog_fail  <= 1'b0;
      wp_fail    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          if (cmd_op == OP_CLEAR) begin
            erase_fail <= 1'b0;
            prog_fail  <= 1'b0;
            wp_fail    <= 1'b0;
          end else if (is_pe) begin
            if (!prog_en) begin
              wp_fail <= 1'b1;
            end else if (any_err) begin
              if (cmd_op == OP_ERASE) erase_fail <= 1'b1;
              else                    prog_fail  <= 1'b1;
              state <= S_BLOCK;
            end else begin
              is_erase <= (cmd_op == OP_ERASE);
              tcnt     <= '0;
              pnum     <= NW'(1);
              state    <= S_PULSE;
            end
          end
        end
        S_PULSE: begin
          if (tcnt == CW'(PULSE_CYCLES - 1)) state <= S_VERIFY;
          else tcnt <= tcnt + 1'b1;
        end
        S_VERIFY: begin
          if (verify_ok) begin
            state <= S_IDLE;
          end else if (pnum == budget) begin
            if (is_erase) erase_fail <= 1'b1;
            else          prog_fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            pnum  <= pnum + 1'b1;
            tcnt  <= '0;
            state <= S_PULSE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_status_chk.sv
module flash_pe_status_chk #(
  parameter int ERASE_MAX = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       prog_en,
  input logic       pulse_on,
  input logic [7:0] status
);
  logic       pulse_q;
  logic [7:0] pcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pcount  <= '0;
    end else begin
      pulse_q <= pulse_on;
      if (status[7])                pcount <= '0;
      else if (pulse_on && !pulse_q) pcount <= pcount + 1'b1;
    end
  end

  wire pe_cmd = cmd_valid && status[7] && (cmd_op == 2'b01 || cmd_op == 2'b10);

  AST_WP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    pe_cmd && !prog_en |=> status[7] && status[3] && !pulse_on); // R6

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[5]) || $fell(status[4]) || $fell(status[3]))
      |-> $past(cmd_valid && cmd_op == 2'b11 && status[7])); // R7

  AST_BLOCK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_cmd && prog_en && (status[5:3] != 3'b000) |=> !status[7] && !pulse_on); // R8

  AST_BLOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_cmd && prog_en && (status[5:3] != 3'b000) |-> ##2 status[7]); // R8

  AST_ERASE_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) && ($past(pcount) != 8'd0) |-> $past(pcount) == 8'(ERASE_MAX)); // R4

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcount <= 8'(ERASE_MAX)); // R3

  AST_IDLE_BUSY_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] && (status[5:3] != 3'b000) |=> status[5:3] != 3'b000); // R9
endmodule

bind flash_pe_status flash_pe_status_chk #(.ERASE_MAX(ERASE_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .prog_en(prog_en), .pulse_on(pulse_on), .status(status)
);

// File: tb/flash_pe_status_tb_top.sv
`timescale 1ns/1ps
module flash_pe_status_tb_top;
  localparam int P  = 3;
  localparam int EM = 8;
  localparam int PM = 4;
  localparam logic [1:0] PROG = 2'b01, ERASE = 2'b10, CLR = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, prog_en = 1'b1, verify_ok = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic pulse_on;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_pe_status #(.PULSE_CYCLES(P), .ERASE_MAX(EM), .PROG_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .prog_en(prog_en), .verify_ok(verify_ok), .pulse_on(pulse_on), .status(status));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge N0, return at N0+1 with cmd released
  task automatic issue(input logic [1:0] op, input logic pe);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; prog_en = pe;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00; prog_en = 1'b1;
  endtask

  task automatic run_op(input logic [1:0] op, input int target, input int maxp, input bit inject);
    int t;
    logic [7:0] flag;
    flag = (op == ERASE) ? 8'h20 : 8'h10;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; prog_en = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
    t = 1;
    chk("R3 busy and pulsing after accept", {status, pulse_on}, {8'h00, 1'b1});
    if (inject) begin cmd_valid = 1'b1; cmd_op = ERASE; prog_en = 1'b0; end
    for (int i = 1; i <= maxp; i++) begin
      while (t < i * (P + 1)) begin
        @(negedge clk); t++;
        if (t == 2) begin cmd_valid = 1'b0; cmd_op = 2'b00; prog_en = 1'b1; end
      end
      chk("R3 busy and no pulse in verify cycle", {status[7], pulse_on}, 0);
      verify_ok = (i == target);
      if (i == target) break;
    end
    @(negedge clk); verify_ok = 1'b0;
    if (target <= maxp)
      chk(inject ? "R9 busy command ignored" : "R3 idle after passing pulse", status, 8'h80);
    else
      chk((op == ERASE) ? "R4 erase fail after budget" : "R5 program fail after budget",
          status, 8'h80 | flag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset release", status, 8'h80);

    issue(2'b00, 1'b1);
    chk("R2 nop code does nothing", {status, pulse_on}, {8'h80, 1'b0});

    for (int t = 1; t <= PM + 1; t++) run_op(PROG, t, PM, 0);

    issue(ERASE, 1'b1);
    chk("R8 rejected erase busy one cycle", {status, pulse_on}, {8'h30, 1'b0});
    @(negedge clk);
    chk("R8 rejected erase flags", status, 8'hB0);
    repeat (5) @(negedge clk);
    chk("R7 flags sticky while idle", status, 8'hB0);
    issue(CLR, 1'b1);
    chk("R10 clear in idle", status, 8'h80);

    issue(PROG, 1'b0);
    chk("R6 write protect sets bit3 stays idle", {status, pulse_on}, {8'h88, 1'b0});
    repeat (4) @(negedge clk);
    chk("R6 no pulse after protected command", {status, pulse_on}, {8'h88, 1'b0});
    issue(PROG, 1'b1);
    chk("R8 rejected program busy", {status, pulse_on}, {8'h18, 1'b0});
    @(negedge clk);
    chk("R8 rejected program flags", status, 8'h98);
    issue(CLR, 1'b1);
    chk("R10 clear after protect", status, 8'h80);

    for (int t = 1; t <= EM + 1; t++) begin
      run_op(ERASE, t, EM, 0);
      if (t > EM) begin
        issue(CLR, 1'b1);
        chk("R10 clear erase flag", status, 8'h80);
      end
    end

    run_op(PROG, 2, PM, 1);
    run_op(ERASE, 3, EM, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule